// File: doc/BRIEF.md
# Sleep and Idle Power Mode Controller

This block governs the two low-power states of a small processor subsystem. The CPU asks for a power-save state with a one-cycle request strobe and a mode bit. From that request and three wake inputs, the block works out which clocks and oscillators may run, and it drives five enables: the CPU clock, the peripheral clock, the main oscillator, the clock-failure monitor and the low-power RC oscillator.

In the deep state (sleep), the main oscillator, the clock-failure monitor and both clocks stop. The low-power RC oscillator keeps running only when the watchdog is enabled, because the watchdog is its only user. In the light state (idle), only the CPU clock stops.

The watchdog gets a clear pulse in the cycle that a sleep request is taken. A pending enabled interrupt, a watchdog time-out or a reset ends either state. After sleep, the block holds the CPU clock off for a settle window while the oscillator restarts. The selected clock source is kept across sleep, so the system resumes on the source it had on entry. A 2-bit output reports what caused the most recent wake.

Top module: `pmc_top`

## Requirements
- R1: While `rst` is high at a clock edge, the block goes to the running state on that edge. In the running state all five enables are high. `active_src` takes the value `DEFAULT_SRC` and `wake_cause` becomes 3 (reset).
- R2: In the running state, a request with `req_mode`=0 (sleep) and no wake event in the same cycle moves the block to sleep on the next edge. In sleep, `cpu_clk_en`, `periph_clk_en`, `osc_en` and `fscm_en` are all low.
- R3: In the running state, a request with `req_mode`=1 (idle) and no wake event moves the block to idle on the next edge. In idle, `cpu_clk_en` is low and `periph_clk_en`, `osc_en` and `fscm_en` stay high.
- R4: In sleep, `lprc_en` equals `wdt_enabled`. In every other state, `lprc_en` is high.
- R5: `wdt_clear` is high, combinationally, exactly when four conditions hold together: the block is running, `req_valid` is high, `req_mode` is 0 and `wdt_enabled` is high. This also holds when the entry is cancelled. In all other cases `wdt_clear` is low.
- R6: A wake event is `irq_wake` or `wdt_timeout`. In idle, a wake event returns the block to running on the next edge. In sleep, a wake event moves the block to the settle state. On either exit, `wake_cause` becomes 2 (watchdog) if `wdt_timeout` is high, and 1 (interrupt) otherwise.
- R7: The settle state lasts exactly `SETTLE_CYCLES` cycles and then the block runs again. During settle, `osc_en` and `lprc_en` are high and `cpu_clk_en`, `periph_clk_en` and `fscm_en` are low.
- R8: The block ignores a request while it is not running. It also ignores wake events in the running state that come without a request, and wake events in the settle state. In these cases the state and `wake_cause` do not change.
- R9: A wake event in the same cycle as a request cancels the entry. The block stays running and `wake_cause` is updated as in R6.
- R10: A source switch (`src_sw_valid`) in the running state loads `src_sw_sel` into `active_src` on the next edge. A switch in any other state is ignored. `active_src` holds its value through sleep, settle and idle.
- R11: A reset in any low-power state returns the block to running on that edge, with `active_src`=`DEFAULT_SRC` and `wake_cause`=3. Reset takes priority over all other inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset; also a wake source |
| req_valid | input | 1 | One-cycle power-save request strobe |
| req_mode | input | 1 | Requested state: 0 sleep, 1 idle |
| irq_wake | input | 1 | An individually enabled interrupt is pending |
| wdt_timeout | input | 1 | Watchdog time-out |
| wdt_enabled | input | 1 | Watchdog is enabled |
| src_sw_valid | input | 1 | Clock source switch strobe |
| src_sw_sel | input | SRC_W | New clock source code |
| cpu_clk_en | output | 1 | CPU clock enable |
| periph_clk_en | output | 1 | Peripheral clock enable |
| osc_en | output | 1 | Main oscillator enable |
| fscm_en | output | 1 | Clock-failure monitor enable |
| lprc_en | output | 1 | Low-power RC oscillator enable |
| wdt_clear | output | 1 | Watchdog clear pulse |
| active_src | output | SRC_W | Selected clock source |
| wake_cause | output | 2 | Last wake cause: 0 none, 1 interrupt, 2 watchdog, 3 reset |

## Verification
The bench builds the block with `SETTLE_CYCLES`=3, `SRC_W`=2 and `DEFAULT_SRC`=1. A settle window of three cycles keeps every sleep exit short, yet it still shows the counter running through its middle value before it releases the CPU clock. A non-zero default source makes the reset restore (R1, R11) visible after the source has been switched to another code. With two source bits, the bench can switch between several codes both inside and outside the running state.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

    typedef enum logic [1:0] {
        PM_RUN   = 2'd0,
        PM_IDLE  = 2'd1,
        PM_SLEEP = 2'd2,
        PM_WAKE  = 2'd3
    } pm_state_t;

    typedef enum logic [1:0] {
        WK_NONE = 2'd0,
        WK_IRQ  = 2'd1,
        WK_WDT  = 2'd2,
        WK_RST  = 2'd3
    } wake_cause_t;

    localparam logic MODE_SLEEP = 1'b0;
    localparam logic MODE_IDLE  = 1'b1;

    typedef struct packed {
        logic cpu;
        logic periph;
        logic osc;
        logic fscm;
        logic lprc;
    } clk_en_t;

    // watchdog time-out outranks a plain interrupt
    function automatic wake_cause_t pick_cause(input logic irq, input logic wdt);
        if (wdt)      return WK_WDT;
        else if (irq) return WK_IRQ;
        else          return WK_NONE;
    endfunction

    function automatic clk_en_t gate_for(input pm_state_t s, input logic wdt_on);
        clk_en_t g;
        case (s)
            PM_RUN:   g = '{cpu: 1'b1, periph: 1'b1, osc: 1'b1, fscm: 1'b1, lprc: 1'b1};
            PM_IDLE:  g = '{cpu: 1'b0, periph: 1'b1, osc: 1'b1, fscm: 1'b1, lprc: 1'b1};
            PM_SLEEP: g = '{cpu: 1'b0, periph: 1'b0, osc: 1'b0, fscm: 1'b0, lprc: wdt_on};
            default:  g = '{cpu: 1'b0, periph: 1'b0, osc: 1'b1, fscm: 1'b0, lprc: 1'b1};
        endcase
        return g;
    endfunction

endpackage

// File: rtl/pmc_fsm.sv
module pmc_fsm
    import pmc_pkg::*;
#(
    parameter int SETTLE_CYCLES = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    input  logic        req_mode,
    input  logic        irq_wake,
    input  logic        wdt_wake,
    output pm_state_t   state,
    output wake_cause_t cause
);
    localparam int CNT_W = (SETTLE_CYCLES > 1) ? $clog2(SETTLE_CYCLES) : 1;

    pm_state_t   state_q;
    wake_cause_t cause_q;
    logic        settle_done;
    logic        wake_ev;

    assign wake_ev = irq_wake | wdt_wake;

    generate
        if (SETTLE_CYCLES > 1) begin : g_settle_cnt
            logic [CNT_W-1:0] cnt_q;
            always_ff @(posedge clk) begin
                if (rst || state_q != PM_WAKE) cnt_q <= '0;
                else if (!settle_done)         cnt_q <= cnt_q + 1'b1;
            end
            assign settle_done = (cnt_q == CNT_W'(SETTLE_CYCLES - 1));
        end else begin : g_settle_none
            assign settle_done = 1'b1;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= PM_RUN;
            cause_q <= WK_RST;
        end else begin
            case (state_q)
                PM_RUN: begin
                    if (req_valid) begin
                        if (wake_ev)                    cause_q <= pick_cause(irq_wake, wdt_wake);
                        else if (req_mode == MODE_IDLE) state_q <= PM_IDLE;
                        else                            state_q <= PM_SLEEP;
                    end
                end
                PM_IDLE: begin
                    if (wake_ev) begin
                        state_q <= PM_RUN;
                        cause_q <= pick_cause(irq_wake, wdt_wake);
                    end
                end
                PM_SLEEP: begin
                    if (wake_ev) begin
                        state_q <= PM_WAKE;
                        cause_q <= pick_cause(irq_wake, wdt_wake);
                    end
                end
                default: begin
                    if (settle_done) state_q <= PM_RUN;
                end
            endcase
        end
    end

    assign state = state_q;
    assign cause = cause_q;

    assert_reset_run_R11: assert property (@(posedge clk)
        rst |=> (state_q == PM_RUN && cause_q == WK_RST));
    assert_idle_exit_R6: assert property (@(posedge clk) disable iff (rst)
        (state_q == PM_IDLE && wake_ev) |=> state_q == PM_RUN);
    assert_sleep_exit_R6: assert property (@(posedge clk) disable iff (rst)
        (state_q == PM_SLEEP && wake_ev) |=> state_q == PM_WAKE);
    assert_sleep_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (state_q == PM_SLEEP && !wake_ev) |=> (state_q == PM_SLEEP && $stable(cause_q)));
    assert_settle_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (state_q == PM_WAKE && !settle_done) |=> (state_q == PM_WAKE && $stable(cause_q)));
    assert_cancel_R9: assert property (@(posedge clk) disable iff (rst)
        (state_q == PM_RUN && req_valid && wake_ev) |=> state_q == PM_RUN);
endmodule

// File: rtl/pmc_src.sv
module pmc_src #(
    parameter int              SRC_W       = 2,
    parameter logic [SRC_W-1:0] DEFAULT_SRC = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_run,
    input  logic             sw_valid,
    input  logic [SRC_W-1:0] sw_sel,
    output logic [SRC_W-1:0] src
);
    logic [SRC_W-1:0] src_q;

    always_ff @(posedge clk) begin
        if (rst)                     src_q <= DEFAULT_SRC;
        else if (in_run && sw_valid) src_q <= sw_sel;
    end

    assign src = src_q;

    assert_src_held_R10: assert property (@(posedge clk) disable iff (rst)
        !in_run |=> $stable(src_q));
endmodule

// File: rtl/pmc_gate.sv
module pmc_gate
    import pmc_pkg::*;
(
    input  pm_state_t state,
    input  logic      wdt_enabled,
    input  logic      req_valid,
    input  logic      req_mode,
    output clk_en_t   en,
    output logic      wdt_clear
);
    always_comb begin
        en        = gate_for(state, wdt_enabled);
        wdt_clear = (state == PM_RUN) && req_valid && (req_mode == MODE_SLEEP) && wdt_enabled;
    end
endmodule

// File: rtl/pmc_top.sv
module pmc_top
    import pmc_pkg::*;
#(
    parameter int               SETTLE_CYCLES = 16,
    parameter int               SRC_W         = 2,
    parameter logic [SRC_W-1:0] DEFAULT_SRC   = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic             req_mode,
    input  logic             irq_wake,
    input  logic             wdt_timeout,
    input  logic             wdt_enabled,
    input  logic             src_sw_valid,
    input  logic [SRC_W-1:0] src_sw_sel,
    output logic             cpu_clk_en,
    output logic             periph_clk_en,
    output logic             osc_en,
    output logic             fscm_en,
    output logic             lprc_en,
    output logic             wdt_clear,
    output logic [SRC_W-1:0] active_src,
    output logic [1:0]       wake_cause
);
    pm_state_t   state;
    wake_cause_t cause;
    clk_en_t     en;

    pmc_fsm #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_mode  (req_mode),
        .irq_wake  (irq_wake),
        .wdt_wake  (wdt_timeout),
        .state     (state),
        .cause     (cause)
    );

    pmc_src #(.SRC_W(SRC_W), .DEFAULT_SRC(DEFAULT_SRC)) u_src (
        .clk      (clk),
        .rst      (rst),
        .in_run   (state == PM_RUN),
        .sw_valid (src_sw_valid),
        .sw_sel   (src_sw_sel),
        .src      (active_src)
    );

    pmc_gate u_gate (
        .state       (state),
        .wdt_enabled (wdt_enabled),
        .req_valid   (req_valid),
        .req_mode    (req_mode),
        .en          (en),
        .wdt_clear   (wdt_clear)
    );

    assign cpu_clk_en    = en.cpu;
    assign periph_clk_en = en.periph;
    assign osc_en        = en.osc;
    assign fscm_en       = en.fscm;
    assign lprc_en       = en.lprc;
    assign wake_cause    = cause;

    assert_cpu_needs_osc_R2: assert property (@(posedge clk) disable iff (rst)
        cpu_clk_en |-> (osc_en && periph_clk_en && fscm_en));
    assert_fscm_needs_osc_R2: assert property (@(posedge clk) disable iff (rst)
        fscm_en |-> osc_en);
    assert_clear_then_sleep_R5: assert property (@(posedge clk) disable iff (rst)
        (wdt_clear && !irq_wake && !wdt_timeout) |=> (!osc_en && !cpu_clk_en));
    assert_lprc_sleep_R4: assert property (@(posedge clk) disable iff (rst)
        (!osc_en && !wdt_enabled) |-> !lprc_en);
endmodule

// File: tb/sim_pmc_top.sv
`timescale 1ns/1ps
module sim_pmc_top;
    localparam int         S   = 3;
    localparam int         SW  = 2;
    localparam logic [1:0] DEF = 2'd1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0, req_mode = 1'b0, irq_wake = 1'b0, wdt_timeout = 1'b0;
    logic wdt_enabled = 1'b1, src_sw_valid = 1'b0;
    logic [SW-1:0] src_sw_sel = '0;
    logic cpu_clk_en, periph_clk_en, osc_en, fscm_en, lprc_en, wdt_clear;
    logic [SW-1:0] active_src;
    logic [1:0] wake_cause;

    int n_run = 0, n_fail = 0;

    always #2.5 clk = ~clk;

    pmc_top #(.SETTLE_CYCLES(S), .SRC_W(SW), .DEFAULT_SRC(DEF)) u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_mode(req_mode),
        .irq_wake(irq_wake), .wdt_timeout(wdt_timeout), .wdt_enabled(wdt_enabled),
        .src_sw_valid(src_sw_valid), .src_sw_sel(src_sw_sel),
        .cpu_clk_en(cpu_clk_en), .periph_clk_en(periph_clk_en), .osc_en(osc_en),
        .fscm_en(fscm_en), .lprc_en(lprc_en), .wdt_clear(wdt_clear),
        .active_src(active_src), .wake_cause(wake_cause)
    );

    // behavioural reference: 0 run, 1 idle, 2 sleep, 3 settle
    int m_st = 0, m_cnt = 0, m_cause = 3;
    logic [SW-1:0] m_src = DEF;

    always @(posedge clk) begin
        if (rst) begin
            m_st = 0; m_cnt = 0; m_cause = 3; m_src = DEF;
        end else begin
            int ev_cause;
            ev_cause = wdt_timeout ? 2 : 1;
            if (m_st == 0) begin
                if (src_sw_valid) m_src = src_sw_sel;
                if (req_valid) begin
                    if (irq_wake || wdt_timeout) m_cause = ev_cause;
                    else m_st = req_mode ? 1 : 2;
                end
            end else if (m_st == 1) begin
                if (irq_wake || wdt_timeout) begin m_st = 0; m_cause = ev_cause; end
            end else if (m_st == 2) begin
                if (irq_wake || wdt_timeout) begin m_st = 3; m_cnt = 0; m_cause = ev_cause; end
            end else begin
                if (m_cnt == S - 1) m_st = 0;
                else m_cnt = m_cnt + 1;
            end
        end
    end

    task automatic check(input string req);
        logic [10:0] got, exp;
        got = {cpu_clk_en, periph_clk_en, osc_en, fscm_en, lprc_en, wdt_clear, active_src, wake_cause, 1'b0};
        exp = {m_st == 0, m_st <= 1, m_st != 2, m_st <= 1,
               (m_st == 2) ? wdt_enabled : 1'b1,
               (m_st == 0) && req_valid && !req_mode && wdt_enabled,
               m_src, 2'(m_cause), 1'b0};
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s t=%0t got %b expected %b", req, $time, got, exp);
        end
    endtask

    // inputs are set by the caller after a negedge; the check follows the next negedge
    task automatic cyc(input string req);
        @(negedge clk); #0.5;
        check(req);
    endtask

    task automatic idle_in();
        req_valid = 0; irq_wake = 0; wdt_timeout = 0; src_sw_valid = 0;
    endtask

    initial begin
        repeat (40000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        rst = 1; idle_in();
        cyc("R1"); cyc("R1");
        rst = 0; cyc("R1");

        // R2/R4/R5 sleep with watchdog on
        req_valid = 1; req_mode = 0; wdt_enabled = 1; cyc("R5");
        idle_in(); cyc("R2"); cyc("R4");
        req_valid = 1; req_mode = 1; cyc("R8");
        idle_in(); src_sw_valid = 1; src_sw_sel = 2'd3; cyc("R10");
        idle_in(); irq_wake = 1; cyc("R6");
        idle_in(); wdt_timeout = 1; cyc("R8");
        idle_in(); cyc("R7"); cyc("R7"); cyc("R7");

        // R3 idle, exit by simultaneous watchdog and interrupt
        irq_wake = 1; cyc("R8");
        idle_in(); req_valid = 1; req_mode = 1; cyc("R3");
        idle_in(); cyc("R3");
        req_valid = 1; req_mode = 0; cyc("R8");
        idle_in(); src_sw_valid = 1; src_sw_sel = 2'd2; cyc("R10");
        idle_in(); irq_wake = 1; wdt_timeout = 1; cyc("R6");
        idle_in(); cyc("R6");

        // R9 cancellation, clear still issued for sleep
        req_valid = 1; req_mode = 0; irq_wake = 1; cyc("R9");
        idle_in(); cyc("R9");
        req_valid = 1; req_mode = 1; wdt_timeout = 1; cyc("R9");
        idle_in(); cyc("R9");

        // R10 switch in run, then sleep with watchdog off
        src_sw_valid = 1; src_sw_sel = 2'd2; cyc("R10");
        idle_in(); wdt_enabled = 0; req_valid = 1; req_mode = 0; cyc("R5");
        idle_in(); cyc("R4"); cyc("R4");
        wdt_timeout = 1; cyc("R6");
        idle_in(); cyc("R7"); cyc("R7"); cyc("R10");

        // R11 reset while asleep
        wdt_enabled = 1; req_valid = 1; req_mode = 0; cyc("R2");
        idle_in(); cyc("R2");
        rst = 1; cyc("R11");
        rst = 0; cyc("R11"); cyc("R1");

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule